// File: doc/BRIEF.md
# Short Frame Padder and CRC-32 Appender

This block sits in a transmit byte path, between a frame source and the line-side logic. Frames arrive as a valid/ready byte stream. Start and end markers frame each packet. Two per-frame option flags come with the stream: one suppresses padding and one suppresses the checksum. The block reads both flags only on the byte that carries the start marker.

When padding is allowed and the payload is shorter than the minimum frame minus the four checksum bytes, the block inserts zero bytes after the payload. A standard CRC-32 trailer follows them. The flags interact: whenever pad bytes are actually inserted, the trailer is also sent, whatever the checksum flag says. Without padding, the trailer is sent only when the checksum flag is clear.

The end marker moves to the last byte the block produces. The source is held off while the inserted bytes are being sent. A single output register gives a clean stall boundary: a stalled byte and its markers stay put until they are taken.

Top module: `padCrcTx`

## Requirements
- R1: During and straight after reset no output byte is offered (outValid low) and the input is ready to take a byte.
- R2: Payload bytes leave unchanged and in order; the start marker goes on the first output byte of a frame and on no other byte.
- R3: When the pad-disable flag is 0 and the payload is shorter than MIN_FRAME-4 bytes (60 by default), 0x00 bytes follow the payload until it is 60 bytes long, and the 4-byte CRC comes after them (64 bytes in total).
- R4: When pad bytes are inserted, the CRC is appended even if the CRC-disable flag is 1.
- R5: When both the pad-disable flag and the CRC-disable flag are 1, the frame leaves exactly as received, with the end marker on its last payload byte.
- R6: When the pad-disable flag is 1 and the CRC-disable flag is 0, a CRC is appended and no pad byte is inserted, however short the frame.
- R7: A payload of 60 or more bytes gets no pad byte; it gets the CRC exactly when the CRC-disable flag is 0.
- R8: The CRC is CRC-32 with reflected polynomial 0xEDB88320, start value 0xFFFFFFFF and final inversion, computed over payload and pad bytes, and sent least significant byte first.
- R9: The pad-disable and CRC-disable flags count only on the byte carrying the start marker; their values on all later bytes of the frame have no effect.
- R10: The end marker goes on the last byte the block produces for a frame. inReady stays low from the cycle after the last payload byte is taken for as long as pad or CRC bytes remain.
- R11: While outValid is high and outReady is low, outValid, outData, outFirst and outLast keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input byte offered |
| inReady | output | 1 | Block takes the input byte at this edge |
| inData | input | 8 | Input byte |
| inFirst | input | 1 | Byte starts a frame |
| inLast | input | 1 | Byte ends the payload |
| inNoPad | input | 1 | Pad-disable flag, read with the start byte |
| inNoCrc | input | 1 | CRC-disable flag, read with the start byte |
| outValid | output | 1 | Output byte offered |
| outReady | input | 1 | Sink takes the output byte |
| outData | output | 8 | Output byte |
| outFirst | output | 1 | Output byte starts a frame |
| outLast | output | 1 | Output byte ends the frame |

## Verification
The properties assume well-formed framing at the input. Every frame opens with a byte carrying inFirst, closes with one carrying inLast, and never nests a second start before the end. Under that assumption, output beats can be counted between start and end markers. The stimulus builds every frame through one task that sets inFirst only on byte zero and inLast only on the final byte. Flag inputs and idle gaps are random, but the markers never are, so the framing assumption holds in every cycle.

// File: rtl/padCrcPkg.sv
package padCrcPkg;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam int          CRC_BYTES = 4;

  typedef enum logic [1:0] {
    ST_PASS,
    ST_PAD,
    ST_CRC
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadIn;
    logic       loadPad;
    logic       loadCrc;
    logic [1:0] crcSel;
  } dpStrobe_t;

  function automatic logic [31:0] crcStep(input logic [31:0] crcIn,
                                          input logic [7:0]  dataIn);
    logic [31:0] c;
    c = crcIn ^ {24'd0, dataIn};
    for (int b = 0; b < 8; b++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/padCrcData.sv
module padCrcData
  import padCrcPkg::*;
#(
  parameter int MIN_FRAME = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  input  logic [7:0] inData,
  input  logic       inFirst,
  input  logic       inLast,
  input  logic       inNoPad,
  input  logic       inNoCrc,
  input  logic       outReady,
  output logic       outValid,
  output logic [7:0] outData,
  output logic       outFirst,
  output logic       outLast,
  output logic       loadOk,
  output logic       needPad,
  output logic       needCrc,
  output logic       padDone
);

  localparam int PAD_TARGET = MIN_FRAME - CRC_BYTES;
  localparam int CNT_W      = $clog2(PAD_TARGET + 1);

  logic [CNT_W-1:0] lenQ;
  logic [CNT_W-1:0] lenAfter;
  logic [31:0]      crcQ;
  logic [31:0]      crcSeed;
  logic [31:0]      crcShift;
  logic             noPadQ;
  logic             noCrcQ;
  logic             startNow;
  logic             effNoPad;
  logic             effNoCrc;
  logic             shortAfter;

  assign loadOk   = !outValid || outReady;
  assign startNow = strobe.loadIn && inFirst;
  assign effNoPad = startNow ? inNoPad : noPadQ;
  assign effNoCrc = startNow ? inNoCrc : noCrcQ;
  assign crcSeed  = startNow ? 32'hFFFFFFFF : crcQ;
  assign crcShift = ~crcQ >> {strobe.crcSel, 3'b000};

  // frame length once the byte loaded this cycle is counted (saturating)
  always_comb begin
    if (startNow)                           lenAfter = CNT_W'(1);
    else if (lenQ == CNT_W'(PAD_TARGET))    lenAfter = lenQ;
    else                                    lenAfter = lenQ + CNT_W'(1);
  end

  assign shortAfter = lenAfter < CNT_W'(PAD_TARGET);
  assign needPad    = !effNoPad && shortAfter;
  assign needCrc    = !effNoCrc || needPad;
  assign padDone    = !shortAfter;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outFirst <= 1'b0;
      outLast  <= 1'b0;
      crcQ     <= 32'hFFFFFFFF;
      lenQ     <= '0;
      noPadQ   <= 1'b0;
      noCrcQ   <= 1'b0;
    end else begin
      if (strobe.loadIn) begin
        outData  <= inData;
        outFirst <= inFirst;
        outLast  <= inLast && !needCrc;
        crcQ     <= crcStep(crcSeed, inData);
        lenQ     <= lenAfter;
        if (inFirst) begin
          noPadQ <= inNoPad;
          noCrcQ <= inNoCrc;
        end
      end else if (strobe.loadPad) begin
        outData  <= 8'h00;
        outFirst <= 1'b0;
        outLast  <= 1'b0;
        crcQ     <= crcStep(crcQ, 8'h00);
        lenQ     <= lenAfter;
      end else if (strobe.loadCrc) begin
        outData  <= crcShift[7:0];
        outFirst <= 1'b0;
        outLast  <= (strobe.crcSel == 2'd3);
      end

      if (strobe.loadIn || strobe.loadPad || strobe.loadCrc) outValid <= 1'b1;
      else if (outReady)                                      outValid <= 1'b0;
    end
  end

endmodule

// File: rtl/padCrcCtrl.sv
module padCrcCtrl
  import padCrcPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inLast,
  input  logic      loadOk,
  input  logic      needPad,
  input  logic      needCrc,
  input  logic      padDone,
  output logic      inReady,
  output dpStrobe_t strobe
);

  ctrlState_e stateQ, stateNext;
  logic [1:0] crcIdxQ;

  always_comb begin
    strobe  = '0;
    inReady = 1'b0;
    unique case (stateQ)
      ST_PASS: begin
        inReady       = loadOk;
        strobe.loadIn = inValid && loadOk;
      end
      ST_PAD:  strobe.loadPad = loadOk;
      ST_CRC: begin
        strobe.loadCrc = loadOk;
        strobe.crcSel  = crcIdxQ;
      end
      default: ;
    endcase
  end

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      ST_PASS: if (inValid && loadOk && inLast)
                 stateNext = needPad ? ST_PAD : (needCrc ? ST_CRC : ST_PASS);
      ST_PAD:  if (loadOk && padDone) stateNext = ST_CRC;
      ST_CRC:  if (loadOk && crcIdxQ == 2'd3) stateNext = ST_PASS;
      default: stateNext = ST_PASS;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_PASS;
      crcIdxQ <= 2'd0;
    end else begin
      stateQ <= stateNext;
      if (strobe.loadCrc) crcIdxQ <= crcIdxQ + 2'd1;
    end
  end

endmodule

// File: rtl/padCrcTx.sv
module padCrcTx
  import padCrcPkg::*;
#(
  parameter int MIN_FRAME = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  input  logic [7:0] inData,
  input  logic       inFirst,
  input  logic       inLast,
  input  logic       inNoPad,
  input  logic       inNoCrc,
  output logic       outValid,
  input  logic       outReady,
  output logic [7:0] outData,
  output logic       outFirst,
  output logic       outLast
);

  dpStrobe_t strobe;
  logic      loadOk;
  logic      needPad;
  logic      needCrc;
  logic      padDone;

  padCrcCtrl ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inLast  (inLast),
    .loadOk  (loadOk),
    .needPad (needPad),
    .needCrc (needCrc),
    .padDone (padDone),
    .inReady (inReady),
    .strobe  (strobe)
  );

  padCrcData #(.MIN_FRAME(MIN_FRAME)) data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inData   (inData),
    .inFirst  (inFirst),
    .inLast   (inLast),
    .inNoPad  (inNoPad),
    .inNoCrc  (inNoCrc),
    .outReady (outReady),
    .outValid (outValid),
    .outData  (outData),
    .outFirst (outFirst),
    .outLast  (outLast),
    .loadOk   (loadOk),
    .needPad  (needPad),
    .needCrc  (needCrc),
    .padDone  (padDone)
  );

endmodule

// File: rtl/padCrcCheck.sv
module padCrcCheck #(
  parameter int MIN_FRAME = 64
) (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inReady,
  input logic       inFirst,
  input logic       inLast,
  input logic       inNoPad,
  input logic       outValid,
  input logic       outReady,
  input logic [7:0] outData,
  input logic       outFirst,
  input logic       outLast
);

  localparam int PAD_TARGET = MIN_FRAME - 4;

  logic [15:0] beatCnt;
  logic        tailPend;
  logic        noPadSeen;
  logic        inTake;
  logic        outTake;

  assign inTake  = inValid && inReady;
  assign outTake = outValid && outReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beatCnt   <= '0;
      tailPend  <= 1'b0;
      noPadSeen <= 1'b0;
    end else begin
      if (outTake && outLast)             beatCnt <= '0;
      else if (outTake && beatCnt != '1)  beatCnt <= beatCnt + 16'd1;
      if (inTake && inFirst) noPadSeen <= inNoPad;
      if (inTake && inLast)          tailPend <= 1'b1;
      else if (outTake && outLast)   tailPend <= 1'b0;
    end
  end

  // R11: stalled output is frozen
  a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outFirst) && $stable(outLast));

  // R10: no new input while appended bytes are still pending
  a_r10_hold_input: assert property (@(posedge clk) disable iff (!rstN)
    tailPend && outValid && !outLast |-> !inReady);

  // R3: a frame with padding allowed never ends below the pad target
  a_r3_min_len: assert property (@(posedge clk) disable iff (!rstN)
    outTake && outLast && !noPadSeen |-> (beatCnt + 16'd1) >= 16'(PAD_TARGET));

  // R2: start marker only on the first beat of a frame
  a_r2_first_at_start: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outFirst |-> beatCnt == 16'd0);

  // R1: nothing offered in the first cycle after reset
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rstN) |-> !outValid);

endmodule

bind padCrcTx padCrcCheck #(.MIN_FRAME(MIN_FRAME)) chk (.*);

// File: tb/padCrcTx_test.sv
module padCrcTx_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid, inReady, inFirst, inLast, inNoPad, inNoCrc;
  logic [7:0] inData;
  logic       outValid, outReady, outFirst, outLast;
  logic [7:0] outData;

  always #5 clk = ~clk;

  padCrcTx #(.MIN_FRAME(64)) uut (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .inFirst(inFirst), .inLast(inLast), .inNoPad(inNoPad), .inNoCrc(inNoCrc),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outFirst(outFirst), .outLast(outLast)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  byte unsigned expData[$];
  bit           expFirst[$];
  bit           expLast[$];
  string        expTag[$];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // R8 reference: bit-serial reflected CRC-32
  function automatic logic [31:0] refCrc(byte unsigned d[$]);
    logic [31:0] r;
    bit fb;
    r = 32'hFFFFFFFF;
    foreach (d[i]) begin
      for (int k = 0; k < 8; k++) begin
        fb = r[0] ^ d[i][k];
        r  = r >> 1;
        if (fb) r = r ^ 32'hEDB88320;
      end
    end
    return ~r;
  endfunction

  task automatic sendFrame(byte unsigned pay[$], bit np, bit nc, string tag);
    byte unsigned full[$];
    bit padIt, crcIt;
    logic [31:0] c;
    full  = pay;
    padIt = !np && pay.size() < 60;
    while (padIt && full.size() < 60) full.push_back(8'h00);
    crcIt = !nc || padIt;
    if (crcIt) begin
      c = refCrc(full);
      for (int k = 0; k < 4; k++) full.push_back(c[8*k +: 8]);
    end
    foreach (full[k]) begin
      expData.push_back(full[k]);
      expFirst.push_back(k == 0);
      expLast.push_back(k == full.size() - 1);
    end
    expTag.push_back(tag);
    foreach (pay[i]) begin
      repeat ($urandom % 3) begin @(posedge clk); #1; end
      inValid = 1'b1;
      inData  = pay[i];
      inFirst = (i == 0);
      inLast  = (i == pay.size() - 1);
      inNoPad = (i == 0) ? np : 1'($urandom);   // R9: later flags random
      inNoCrc = (i == 0) ? nc : 1'($urandom);
      @(negedge clk);
      while (!inReady) @(negedge clk);
      @(posedge clk); #1;
      inValid = 1'b0; inFirst = 1'b0; inLast = 1'b0;
      inNoPad = 1'($urandom); inNoCrc = 1'($urandom);
    end
    if (crcIt) begin
      @(negedge clk);
      check(inReady == 1'b0, "R10", "inReady while appending", int'(inReady), 0);
    end
  endtask

  task automatic runFrame(int len, bit np, bit nc);
    byte unsigned pay[$];
    string base;
    bit padIt;
    for (int i = 0; i < len; i++) pay.push_back(8'($urandom));
    padIt = !np && len < 60;
    if (np) base = nc ? "R5" : "R6";
    else if (len < 60) base = nc ? "R4 R3" : "R3";
    else base = "R7";
    sendFrame(pay, np, nc, $sformatf("%s R2%s%s len=%0d", base,
              (!nc || padIt) ? " R8" : "", len > 1 ? " R9" : "", len));
  endtask

  // output monitor and scoreboard
  initial begin
    bit prevStall = 0;
    logic [7:0] pData = 0;
    logic pFirst = 0, pLast = 0;
    bit frameBad = 0;
    int actV = 0, expV = 0;
    outReady = 1'b0;
    @(posedge rstN);
    forever begin
      @(posedge clk); #1;
      outReady = ($urandom % 10) < 7;
      @(negedge clk);
      if (prevStall) begin
        check(outValid && outData == pData && outFirst == pFirst && outLast == pLast,
              "R11", "stalled output changed", {outValid, outFirst, outLast, outData},
              {1'b1, pFirst, pLast, pData});
      end
      prevStall = outValid && !outReady;
      pData = outData; pFirst = outFirst; pLast = outLast;
      if (outValid && outReady) begin
        if (expData.size() == 0) begin
          check(1'b0, "R2", "unexpected output byte", int'(outData), 0);
        end else begin
          byte unsigned e;
          bit ef, el;
          e  = expData.pop_front();
          ef = expFirst.pop_front();
          el = expLast.pop_front();
          if (!frameBad && (outData != e || outFirst != ef || outLast != el)) begin
            frameBad = 1;
            actV = {outFirst, outLast, outData};
            expV = {ef, el, e};
          end
          if (el) begin
            check(!frameBad, expTag.pop_front(), "frame content {first,last,byte}", actV, expV);
            frameBad = 0;
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    byte unsigned vec[$];
    int w;
    void'($urandom(32'd20240611));
    inValid = 0; inData = 0; inFirst = 0; inLast = 0; inNoPad = 0; inNoCrc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid in reset", int'(outValid), 0);
    check(inReady == 1'b1, "R1", "inReady in reset", int'(inReady), 1);
    @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid after reset", int'(outValid), 0);
    @(posedge clk); #1;

    // R8 known vector "123456789", CRC only
    for (int i = 0; i < 9; i++) vec.push_back(8'h31 + 8'(i));
    sendFrame(vec, 1'b1, 1'b0, "R8 R6 check-vector");

    runFrame(1, 0, 0);
    runFrame(59, 0, 0);
    runFrame(60, 0, 0);
    runFrame(61, 0, 1);
    runFrame(20, 0, 1);
    runFrame(10, 1, 1);
    runFrame(10, 1, 0);
    runFrame(64, 1, 1);
    runFrame(1, 1, 1);
    for (int n = 0; n < 40; n++) runFrame(1 + ($urandom % 90), 1'($urandom), 1'($urandom));

    w = 0;
    while (expData.size() > 0 && w < 5000) begin @(posedge clk); w++; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(expData.size() == 0, "R2", "bytes still expected", expData.size(), 0);
    check(outValid == 1'b0, "R5", "output idle after drain", int'(outValid), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule